// File: doc/BRIEF.md
# Pausable Serial Register Writer

This block is a serial slave port. An external master shifts 24-bit words into it, and each finished word lands in one of two holding registers: a control register or a calibration register. The master drives four lines: a serial clock, an active-low frame strobe, a data line and a destination select line. All four come from outside the system clock domain. They are synchronised and edge-detected on the system clock, `clk`, which must run at least four times as fast as the serial clock.

The master may release the frame strobe in the middle of a word, while the serial clock is low. Serial clock edges seen during that pause are ignored. When the strobe is asserted again, the next rising edge captures the next bit of the same word, because the bit position is kept.

A finished word produces a one-cycle commit indication together with its destination. The output side is valid-only. The holding registers always accept, so there is no back-pressure and no ready signal. A data-ready status line runs through the block untouched, and writes never depend on it.

Top module: `sreg_writer`

## Requirements
- R1: A holding register changes only when the 24th accepted bit of a word arrives. Fewer accepted bits never write anything.
- R2: The first accepted bit of a word becomes bit 23 of the stored value and the last becomes bit 0 (MSB first).
- R3: A bit is taken from the synchronised data line on each synchronised rising edge of the serial clock, provided the synchronised frame strobe is low.
- R4: The select line is sampled with the first bit of a word. Select 0 writes the control register and select 1 writes the calibration register. The other register keeps its value, and `commit_dest_o` reports the destination (0 = control, 1 = calibration).
- R5: While the frame strobe is high, rising serial clock edges shift nothing and the bit position is held. After the strobe is asserted again, the next edge captures the following bit of the same word.
- R6: If the select line differs from its first-bit value on any later bit of the word, the word ends with a one-cycle `word_err_o` pulse and no commit, and neither register changes.
- R7: `drdy_n_o` always equals `drdy_n_i`, whatever the serial traffic.
- R8: A synchronous reset clears the bit position, any partial word and both registers to zero. A word sent after a reset starts at bit 23.
- R9: `commit_o` is high for exactly one cycle per completed word, in the same cycle the register shows the new value. The next word starts again at bit 23.
- R10: The commit is a valid-only indication with no ready signal. The holding registers accept every commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sclk_i | input | 1 | Serial clock from the master, idles low |
| frame_n_i | input | 1 | Active-low frame strobe |
| sdata_i | input | 1 | Serial data, MSB first |
| sel_i | input | 1 | Destination select, 0 = control, 1 = calibration |
| drdy_n_i | input | 1 | Data-ready status in |
| drdy_n_o | output | 1 | Data-ready status out, equal to `drdy_n_i` |
| ctrl_q | output | 24 | Control register contents |
| cal_q | output | 24 | Calibration register contents |
| commit_o | output | 1 | One-cycle pulse: a word was written |
| commit_dest_o | output | 1 | Destination of the current commit |
| word_err_o | output | 1 | One-cycle pulse: a word was discarded because select changed |

## Verification
On every cycle, the embedded assertions check the following:
- the bit position stays in range and holds while the frame strobe is high;
- a finished word coincides with an accepted edge;
- the commit is a single-cycle pulse;
- the registers stay still when no commit happens, and the register that is not the destination stays still during a commit.

Some behaviours only the bench's scenarios can show:
- the MSB-first bit order;
- correct continuation after a mid-word pause with the clock toggling;
- the discard of a word whose select line changed;
- a restart at bit 23 after a reset or a commit;
- the data-ready pass-through.

The bench shows these by comparing the registers against a scoreboard.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  typedef enum logic {
    DEST_CTRL = 1'b0,
    DEST_CAL  = 1'b1
  } dest_e;
endpackage

// File: rtl/sreg_sync.sv
module sreg_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q_o  <= '0;
    end else begin
      meta <= d_i;
      q_o  <= meta;
    end
  end
endmodule

// File: rtl/sreg_shifter.sv
module sreg_shifter
  import sreg_pkg::*;
#(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sclk_s,
  input  logic         frame_n_s,
  input  logic         sdata_s,
  input  logic         sel_s,
  output logic         done_ok_o,
  output logic         err_o,
  output logic [W-1:0] word_o,
  output dest_e        dest_o
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic          sclk_d;
  logic          take;
  logic [CW-1:0] cnt;
  logic [W-1:0]  shreg;
  logic          sel_lat;
  logic          mis;
  logic          mis_now;

  assign take    = sclk_s & ~sclk_d & ~frame_n_s;
  assign mis_now = (cnt != '0) && (sel_s != sel_lat);

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d    <= 1'b0;
      cnt       <= '0;
      shreg     <= '0;
      sel_lat   <= 1'b0;
      mis       <= 1'b0;
      done_ok_o <= 1'b0;
      err_o     <= 1'b0;
      word_o    <= '0;
      dest_o    <= DEST_CTRL;
    end else begin
      sclk_d    <= sclk_s;
      done_ok_o <= 1'b0;
      err_o     <= 1'b0;
      if (take) begin
        shreg <= {shreg[W-2:0], sdata_s};
        if (cnt == '0) sel_lat <= sel_s;
        if (cnt == LAST) begin
          cnt    <= '0;
          mis    <= 1'b0;
          word_o <= {shreg[W-2:0], sdata_s};
          dest_o <= sel_lat ? DEST_CAL : DEST_CTRL;
          if (mis || mis_now) err_o <= 1'b1;
          else done_ok_o <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
          if (mis_now) mis <= 1'b1;
        end
      end
    end
  end

  assert_cnt_range_R1: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);

  assert_pause_holds_R5: assert property (@(posedge clk) disable iff (rst)
    frame_n_s |=> $stable(cnt));

  assert_done_on_edge_R3: assert property (@(posedge clk) disable iff (rst)
    (done_ok_o || err_o) |-> $past(take));
endmodule

// File: rtl/sreg_regs.sv
module sreg_regs
  import sreg_pkg::*;
#(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  dest_e        wr_dest,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] ctrl_q,
  output logic [W-1:0] cal_q,
  output logic         commit_o,
  output logic         commit_dest_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q        <= '0;
      cal_q         <= '0;
      commit_o      <= 1'b0;
      commit_dest_o <= 1'b0;
    end else begin
      commit_o <= wr_en;
      if (wr_en) begin
        commit_dest_o <= wr_dest;
        if (wr_dest == DEST_CAL) cal_q <= wr_data;
        else ctrl_q <= wr_data;
      end
    end
  end

  assert_commit_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    commit_o |=> !commit_o);

  assert_hold_no_write_R1: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(ctrl_q) && $stable(cal_q)));

  assert_other_kept_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_dest == DEST_CAL) |=> $stable(ctrl_q));

  assert_other_kept_ctrl_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_dest == DEST_CTRL) |=> $stable(cal_q));
endmodule

// File: rtl/sreg_writer.sv
module sreg_writer
  import sreg_pkg::*;
#(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sclk_i,
  input  logic         frame_n_i,
  input  logic         sdata_i,
  input  logic         sel_i,
  input  logic         drdy_n_i,
  output logic         drdy_n_o,
  output logic [W-1:0] ctrl_q,
  output logic [W-1:0] cal_q,
  output logic         commit_o,
  output logic         commit_dest_o,
  output logic         word_err_o
);
  logic [3:0]   raw_in;
  logic [3:0]   syn;
  logic         done_ok;
  logic [W-1:0] word;
  dest_e        dest;

  assign raw_in   = {sclk_i, frame_n_i, sdata_i, sel_i};
  assign drdy_n_o = drdy_n_i;

  sreg_sync #(.W(4)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (raw_in),
    .q_o (syn)
  );

  sreg_shifter #(.W(W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .sclk_s    (syn[3]),
    .frame_n_s (syn[2]),
    .sdata_s   (syn[1]),
    .sel_s     (syn[0]),
    .done_ok_o (done_ok),
    .err_o     (word_err_o),
    .word_o    (word),
    .dest_o    (dest)
  );

  sreg_regs #(.W(W)) u_regs (
    .clk           (clk),
    .rst           (rst),
    .wr_en         (done_ok),
    .wr_dest       (dest),
    .wr_data       (word),
    .ctrl_q        (ctrl_q),
    .cal_q         (cal_q),
    .commit_o      (commit_o),
    .commit_dest_o (commit_dest_o)
  );
endmodule

// File: tb/tb_sreg_writer.sv
module tb_sreg_writer;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk_i = 1'b0, frame_n_i = 1'b1, sdata_i = 1'b0, sel_i = 1'b0, drdy_n_i = 1'b1;
  logic drdy_n_o, commit_o, commit_dest_o, word_err_o;
  logic [23:0] ctrl_q, cal_q;

  int checks = 0;
  int fails  = 0;
  int exp_err = 0;
  int seen_err = 0;
  bit finished = 0;
  logic [24:0] sb_q[$];
  logic [23:0] m_ctrl = '0, m_cal = '0;

  always #10 clk = ~clk;

  sreg_writer dut (
    .clk(clk), .rst(rst), .sclk_i(sclk_i), .frame_n_i(frame_n_i),
    .sdata_i(sdata_i), .sel_i(sel_i), .drdy_n_i(drdy_n_i), .drdy_n_o(drdy_n_o),
    .ctrl_q(ctrl_q), .cal_q(cal_q), .commit_o(commit_o),
    .commit_dest_o(commit_dest_o), .word_err_o(word_err_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  // Shift nbits of data (from bit 23 down); pause after bit pause_at; flip sel from bit glitch_at.
  task automatic send_bits(input logic [23:0] data, input bit sel, input int nbits,
                           input int pause_at, input int glitch_at);
    frame_n_i = 1'b0;
    for (int i = 0; i < nbits; i++) begin
      sdata_i = data[23 - i];
      sel_i   = (glitch_at >= 0 && i >= glitch_at) ? ~sel : sel;
      waitn(2);
      sclk_i = 1'b1;
      waitn(4);
      sclk_i = 1'b0;
      waitn(2);
      if (i == pause_at) begin
        frame_n_i = 1'b1;
        for (int p = 0; p < 3; p++) begin
          sdata_i = ~sdata_i;
          sel_i   = ~sel_i;
          waitn(2); sclk_i = 1'b1; waitn(4); sclk_i = 1'b0; waitn(2);
        end
        sel_i = sel;
        waitn(3);
        frame_n_i = 1'b0;
        waitn(3);
      end
    end
    frame_n_i = 1'b1;
    waitn(6);
  endtask

  task automatic send_word(input logic [23:0] data, input bit sel, input int pause_at, input int glitch_at);
    if (glitch_at >= 0) exp_err++;
    else sb_q.push_back({sel, data});
    send_bits(data, sel, 24, pause_at, glitch_at);
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (word_err_o) seen_err++;
      if (commit_o) begin
        if (sb_q.size() == 0) begin
          chk(1'b0, "R1 unexpected commit", {8'h0, ctrl_q}, 32'h0);
        end else begin
          logic [24:0] e;
          e = sb_q.pop_front();
          if (e[24]) m_cal = e[23:0]; else m_ctrl = e[23:0];
          chk(commit_dest_o == e[24], "R4 dest", {31'h0, commit_dest_o}, {31'h0, e[24]});
          chk(ctrl_q == m_ctrl, "R2 ctrl value", {8'h0, ctrl_q}, {8'h0, m_ctrl});
          chk(cal_q == m_cal, "R2 cal value", {8'h0, cal_q}, {8'h0, m_cal});
        end
      end
    end
  end

  // R9: commit width one cycle
  always @(negedge clk) begin
    if (!rst && commit_o) begin
      @(negedge clk);
      chk(!commit_o, "R9 pulse width", {31'h0, commit_o}, 32'h0);
    end
  end

  initial begin
    waitn(200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    waitn(4);
    rst = 1'b0;
    waitn(2);
    // R8 reset state
    chk(ctrl_q == 0 && cal_q == 0, "R8 reset regs", {8'h0, ctrl_q | cal_q}, 32'h0);
    chk(!commit_o && !word_err_o, "R8 reset pulses", {30'h0, commit_o, word_err_o}, 32'h0);
    // R7 passthrough
    drdy_n_i = 1'b0; waitn(1);
    chk(drdy_n_o == 1'b0, "R7 drdy pass", {31'h0, drdy_n_o}, 32'h0);
    // R2/R4/R9/R10 basic words back to back
    send_word(24'hA5C3F1, 1'b0, -1, -1);
    send_word(24'h13579B, 1'b1, -1, -1);
    send_word(24'h800001, 1'b0, -1, -1);
    drdy_n_i = 1'b1; waitn(1);
    chk(drdy_n_o == 1'b1, "R7 drdy pass after writes", {31'h0, drdy_n_o}, 32'h1);
    // R5 pause mid-word with clock toggles
    send_word(24'h3CF00F, 1'b1, 9, -1);
    send_word(24'h7E0181, 1'b0, 0, -1);
    // R6 select changes mid-word: discarded
    send_word(24'hFFFFFF, 1'b0, -1, 12);
    chk(ctrl_q == m_ctrl && cal_q == m_cal, "R6 regs kept", {8'h0, ctrl_q}, {8'h0, m_ctrl});
    send_word(24'h000000, 1'b1, -1, 23);
    chk(ctrl_q == m_ctrl && cal_q == m_cal, "R6 regs kept last bit", {8'h0, cal_q}, {8'h0, m_cal});
    // R1 partial word then reset: no write, R8 restart from bit 23
    send_bits(24'hDEADBE, 1'b0, 10, -1, -1);
    chk(ctrl_q == m_ctrl && cal_q == m_cal, "R1 partial no write", {8'h0, ctrl_q}, {8'h0, m_ctrl});
    rst = 1'b1; waitn(2); rst = 1'b0; waitn(2);
    m_ctrl = '0; m_cal = '0;
    chk(ctrl_q == 0 && cal_q == 0, "R8 reset clears regs", {8'h0, ctrl_q | cal_q}, 32'h0);
    send_word(24'hC0FFEE, 1'b0, -1, -1);
    send_word(24'h2468AC, 1'b1, 20, -1);
    waitn(10);
    chk(sb_q.size() == 0, "R1 all words committed", sb_q.size(), 32'h0);
    chk(seen_err == exp_err, "R6 error pulses", seen_err, exp_err);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule